// File: doc/BRIEF.md
# ATAN2 Special-Value Resolver

This block sits in front of a single-precision two-operand arc-tangent unit, atan2(y, x). It takes one pair of FP32 operands per transfer and sorts each operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From the two classes it decides whether the answer is known exactly without any arithmetic. If it is, the block returns the exact FP32 result and raises a bypass flag. If it is not, it raises a flag that sends the pair down the general arc-tangent path. The operands are passed through unchanged so that the general path can use them.

The decision follows a fixed priority. A NaN operand wins first, and x is checked before y. Infinite operands come next, then zero operands. Only a pair of finite, nonzero operands reaches the general path. Every constant result (0, π/4, π/2, 3π/4, π) takes the sign bit of y. Transfers use a valid/ready handshake. By default a single output register adds one cycle of latency and holds its contents while the consumer stalls. A parameter can remove that register so the block becomes purely combinational.

Top module: `atan2_special_resolver`

## Requirements
- R1: If x is a NaN (exponent 0xFF, mantissa nonzero), the result is x with mantissa bit 22 forced to 1. Otherwise, if y is a NaN, the result is y with bit 22 forced to 1. Every NaN result has bit 22 set.
- R2: out_invalid is 1 exactly when at least one operand is a signalling NaN (exponent 0xFF, mantissa nonzero, bit 22 clear). It is 0 for every other pair.
- R3: If x is +inf, the result is 0x3F490FDB (π/4) when y is ±inf and 0x00000000 (zero) when y is finite. Bit 31 of the result is always copied from y.
- R4: If x is -inf, the result is 0x4016CBE4 (3π/4) when y is ±inf and 0x40490FDB (π) when y is finite. The sign is copied from y.
- R5: If x is finite and y is ±inf, the result is 0x3FC90FDB (π/2) with the sign of y.
- R6: If x is ±0 and y is finite and nonzero, the result is π/2 (0x3FC90FDB) with the sign of y.
- R7: If y is ±0 and x is finite, the result is signed zero when bit 31 of x is 0 and π when bit 31 of x is 1. The sign is copied from y. Both zeros of x follow this rule.
- R8: A subnormal operand (exponent 0, mantissa nonzero) counts as a finite nonzero value, never as a zero.
- R9: When both operands are finite and nonzero, out_general is 1, out_bypass is 0 and out_result is 0. On every output transfer exactly one of out_bypass and out_general is 1, and out_y and out_x equal the operands that were accepted.
- R10: With the output register in place, a pair accepted at one clock edge appears at the output on the next edge. in_ready is 1 whenever the output is empty or is being consumed. While out_valid is 1 and out_ready is 0, every output holds its value.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_y | input | 32 | FP32 operand y (numerator) |
| in_x | input | 32 | FP32 operand x (denominator) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Exact FP32 result when bypassing, otherwise 0 |
| out_bypass | output | 1 | Result is exact; the general path is skipped |
| out_general | output | 1 | General arc-tangent path must run |
| out_invalid | output | 1 | A signalling NaN operand was seen |
| out_y | output | 32 | Operand y passed through |
| out_x | output | 32 | Operand x passed through |

## Verification
An operand put in the wrong class, or a rule tested in the wrong order, shows up on the very next output transfer of the pair that caused it. It appears as a wrong constant, a sign taken from the wrong operand, a NaN left unquieted, or the bypass and general flags swapped. A fault in the output register or the handshake shows up at once as a dropped, repeated or reordered transfer. It can also show as an output that changes while the consumer is stalled. Every pairing of the special operand classes is applied under random backpressure. Each output transfer is compared with a model that does not look inside the block, so any such fault shows on the transfer it affects.

// File: rtl/atan2_sv_pkg.sv
package atan2_sv_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int QBIT   = MAN_W - 1;

    localparam logic [FP_W-2:0] MAG_PI     = 31'h40490FDB;
    localparam logic [FP_W-2:0] MAG_PI_2   = 31'h3FC90FDB;
    localparam logic [FP_W-2:0] MAG_PI_4   = 31'h3F490FDB;
    localparam logic [FP_W-2:0] MAG_3PI_4  = 31'h4016CBE4;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fp_cls_e;

    typedef struct packed {
        fp_cls_e cls;
        logic    sign;
    } opnd_info_t;

    typedef struct packed {
        logic [FP_W-1:0] res;
        logic            bypass;
        logic            general;
        logic            invalid;
    } verdict_t;

    typedef struct packed {
        verdict_t        vd;
        logic [FP_W-1:0] y;
        logic [FP_W-1:0] x;
    } payload_t;

    function automatic logic cls_is_nan(fp_cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic cls_is_finite(fp_cls_e c);
        return (c == CLS_ZERO) || (c == CLS_SUB) || (c == CLS_NORM);
    endfunction

endpackage

// File: rtl/atan2_fp_classify.sv
module atan2_fp_classify
    import atan2_sv_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int M_W = MAN_W
) (
    input  logic [E_W+M_W:0] val,
    output opnd_info_t       info
);
    localparam logic [E_W-1:0] EXP_ONES = '1;

    logic [E_W-1:0] ex;
    logic [M_W-1:0] mn;

    always_comb begin
        ex        = val[E_W+M_W-1:M_W];
        mn        = val[M_W-1:0];
        info.sign = val[E_W+M_W];
        if (ex == EXP_ONES) begin
            if (mn == '0)          info.cls = CLS_INF;
            else if (mn[M_W-1])    info.cls = CLS_QNAN;
            else                   info.cls = CLS_SNAN;
        end else if (ex == '0) begin
            // subnormals stay nonzero (R8)
            info.cls = (mn == '0) ? CLS_ZERO : CLS_SUB;
        end else begin
            info.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/atan2_rule_table.sv
module atan2_rule_table
    import atan2_sv_pkg::*;
(
    input  logic [FP_W-1:0] y,
    input  logic [FP_W-1:0] x,
    input  opnd_info_t      yi,
    input  opnd_info_t      xi,
    output verdict_t        vd
);
    localparam logic [FP_W-1:0] QUIET_MASK = FP_W'(1) << QBIT;

    logic ys;

    always_comb begin
        ys         = yi.sign;
        vd         = '0;
        vd.bypass  = 1'b1;
        vd.invalid = (xi.cls == CLS_SNAN) || (yi.cls == CLS_SNAN);
        if (cls_is_nan(xi.cls)) begin
            vd.res = x | QUIET_MASK;
        end else if (cls_is_nan(yi.cls)) begin
            vd.res = y | QUIET_MASK;
        end else if (xi.cls == CLS_INF && !xi.sign) begin
            vd.res = (yi.cls == CLS_INF) ? {ys, MAG_PI_4} : {ys, 31'b0};
        end else if (xi.cls == CLS_INF) begin
            vd.res = (yi.cls == CLS_INF) ? {ys, MAG_3PI_4} : {ys, MAG_PI};
        end else if (yi.cls == CLS_INF) begin
            vd.res = {ys, MAG_PI_2};
        end else if (xi.cls == CLS_ZERO && yi.cls != CLS_ZERO) begin
            vd.res = {ys, MAG_PI_2};
        end else if (yi.cls == CLS_ZERO) begin
            vd.res = xi.sign ? {ys, MAG_PI} : {ys, 31'b0};
        end else begin
            vd.bypass  = 1'b0;
            vd.general = 1'b1;
        end
    end
endmodule

// File: rtl/atan2_out_stage.sv
module atan2_out_stage
    import atan2_sv_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     up_valid,
    output logic     up_ready,
    input  payload_t up_pl,
    output logic     dn_valid,
    input  logic     dn_ready,
    output payload_t dn_pl
);
    generate
        if (REGISTERED) begin : g_reg
            typedef struct packed {
                logic     vld;
                payload_t pl;
            } stage_t;

            stage_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (dn_ready) st_d.vld = 1'b0;
                if (up_valid && up_ready) begin
                    st_d.vld = 1'b1;
                    st_d.pl  = up_pl;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign up_ready = !st_q.vld || dn_ready;
            assign dn_valid = st_q.vld;
            assign dn_pl    = st_q.pl;
        end else begin : g_pass
            assign up_ready = dn_ready;
            assign dn_valid = up_valid;
            assign dn_pl    = up_pl;
        end
    endgenerate
endmodule

// File: rtl/atan2_special_resolver.sv
module atan2_special_resolver
    import atan2_sv_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [FP_W-1:0] in_y,
    input  logic [FP_W-1:0] in_x,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [FP_W-1:0] out_result,
    output logic            out_bypass,
    output logic            out_general,
    output logic            out_invalid,
    output logic [FP_W-1:0] out_y,
    output logic [FP_W-1:0] out_x
);
    localparam int N_OPND = 2;

    logic [N_OPND-1:0][FP_W-1:0] opnd;
    opnd_info_t                  info [N_OPND];
    verdict_t                    vd;
    payload_t                    pl_in, pl_out;

    assign opnd[0] = in_x;
    assign opnd[1] = in_y;

    generate
        for (genvar i = 0; i < N_OPND; i++) begin : g_cls
            atan2_fp_classify #(.E_W(EXP_W), .M_W(MAN_W)) u_cls (
                .val  (opnd[i]),
                .info (info[i])
            );
        end
    endgenerate

    atan2_rule_table u_rules (
        .y  (in_y),
        .x  (in_x),
        .yi (info[1]),
        .xi (info[0]),
        .vd (vd)
    );

    assign pl_in.vd = vd;
    assign pl_in.y  = in_y;
    assign pl_in.x  = in_x;

    atan2_out_stage #(.REGISTERED(REGISTERED)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_pl    (pl_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_pl    (pl_out)
    );

    assign out_result  = pl_out.vd.res;
    assign out_bypass  = pl_out.vd.bypass;
    assign out_general = pl_out.vd.general;
    assign out_invalid = pl_out.vd.invalid;
    assign out_y       = pl_out.y;
    assign out_x       = pl_out.x;
endmodule

// File: rtl/atan2_special_resolver_chk.sv
module atan2_special_resolver_chk #(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_result,
    input logic        out_bypass,
    input logic        out_general,
    input logic        out_invalid,
    input logic [31:0] out_y,
    input logic [31:0] out_x
);
    logic res_nan;
    assign res_nan = (out_result[30:23] == 8'hFF) && (out_result[22:0] != 23'd0);

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({out_bypass, out_general}));

    assert_general_finite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_general) |->
            (out_x[30:23] != 8'hFF) && (out_y[30:23] != 8'hFF) &&
            (out_x[30:0] != 31'd0) && (out_y[30:0] != 31'd0));

    assert_quiet_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_nan) |-> out_result[22]);

    assert_sign_from_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bypass && !res_nan) |-> (out_result[31] == out_y[31]));

    assert_invalid_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_bypass && res_nan));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (REGISTERED && out_valid && !out_ready) |=>
            (out_valid && $stable(out_result) && $stable(out_bypass) &&
             $stable(out_y) && $stable(out_x)));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (REGISTERED && in_valid && in_ready) |=> out_valid);
endmodule

bind atan2_special_resolver atan2_special_resolver_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_bypass  (out_bypass),
    .out_general (out_general),
    .out_invalid (out_invalid),
    .out_y       (out_y),
    .out_x       (out_x)
);

// File: tb/atan2_special_resolver_test.sv
`timescale 1ns/1ps
module atan2_special_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_y = '0;
    logic [31:0] in_x = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_result;
    logic        out_bypass, out_general, out_invalid;
    logic [31:0] out_y, out_x;

    always #2.5 clk = ~clk;

    atan2_special_resolver uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_y (in_y), .in_x (in_x),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_result (out_result), .out_bypass (out_bypass),
        .out_general (out_general), .out_invalid (out_invalid),
        .out_y (out_y), .out_x (out_x)
    );

    typedef struct {
        logic [31:0] y, x, res;
        logic        byp, gen, inv;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   ready_pct = 100;
    bit   done = 0;

    logic [31:0] pool [14];
    initial begin
        pool[0]  = 32'h00000000; pool[1]  = 32'h80000000;
        pool[2]  = 32'h7F800000; pool[3]  = 32'hFF800000;
        pool[4]  = 32'h7FC00001; pool[5]  = 32'h7F800005;
        pool[6]  = 32'hFFA00000; pool[7]  = 32'h00000001;
        pool[8]  = 32'h80400000; pool[9]  = 32'h3F800000;
        pool[10] = 32'hC0200000; pool[11] = 32'h7F7FFFFF;
        pool[12] = 32'hFFC00000; pool[13] = 32'h00800000;
    end

    function automatic bit f_nan(logic [31:0] v);  return v[30:23] == 8'hFF && v[22:0] != 0; endfunction
    function automatic bit f_inf(logic [31:0] v);  return v[30:23] == 8'hFF && v[22:0] == 0; endfunction
    function automatic bit f_zero(logic [31:0] v); return v[30:0] == 0; endfunction
    function automatic bit f_snan(logic [31:0] v); return f_nan(v) && !v[22]; endfunction

    function automatic exp_t ref_model(logic [31:0] y, logic [31:0] x);
        exp_t e;
        logic s;
        s = y[31];
        e.y = y; e.x = x; e.byp = 1; e.gen = 0; e.res = 0;
        e.inv = f_snan(x) || f_snan(y);
        if (f_nan(x))                   begin e.res = x | 32'h00400000; e.tag = "R1"; end
        else if (f_nan(y))              begin e.res = y | 32'h00400000; e.tag = "R1"; end
        else if (x == 32'h7F800000)     begin e.res = f_inf(y) ? {s, 31'h3F490FDB} : {s, 31'h0}; e.tag = "R3"; end
        else if (x == 32'hFF800000)     begin e.res = f_inf(y) ? {s, 31'h4016CBE4} : {s, 31'h40490FDB}; e.tag = "R4"; end
        else if (f_inf(y))              begin e.res = {s, 31'h3FC90FDB}; e.tag = "R5"; end
        else if (f_zero(x) && !f_zero(y)) begin e.res = {s, 31'h3FC90FDB}; e.tag = "R6"; end
        else if (f_zero(y))             begin e.res = x[31] ? {s, 31'h40490FDB} : {s, 31'h0}; e.tag = "R7"; end
        else begin
            e.byp = 0; e.gen = 1;
            e.tag = (x[30:23] == 0 || y[30:23] == 0) ? "R8" : "R9";
        end
        return e;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // one clock cycle; entered and left 1 ns after a rising edge
    task automatic step(output bit accepted);
        exp_t e;
        out_ready = ($urandom_range(99) < ready_pct);
        #1;
        chk(in_ready == (!out_valid || out_ready), "R10", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
        if (out_valid && !(exp_q.size() > 0)) chk(0, "R10", "unexpected output", 32'(out_valid), 0);
        if (out_valid && out_ready && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(out_result == e.res, e.tag, "result", out_result, e.res);
            chk(out_bypass == e.byp && out_general == e.gen, (e.byp ? e.tag : "R9"), "flags",
                {30'b0, out_bypass, out_general}, {30'b0, e.byp, e.gen});
            chk(out_invalid == e.inv, "R2", "invalid", 32'(out_invalid), 32'(e.inv));
            chk(out_y == e.y && out_x == e.x, "R9", "passthrough y", out_y, e.y);
        end
        accepted = in_valid && in_ready;
        if (accepted) exp_q.push_back(ref_model(in_y, in_x));
        @(posedge clk);
        #1;
    endtask

    task automatic send(logic [31:0] y, logic [31:0] x);
        bit acc;
        in_valid = 1; in_y = y; in_x = x;
        do step(acc); while (!acc);
        in_valid = 0;
    endtask

    initial begin
        bit acc;
        #12;
        // R11: reset state
        chk(out_valid == 0, "R11", "out_valid in reset", 32'(out_valid), 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk(out_valid == 0 && in_ready == 1, "R11", "idle after reset", {30'b0, out_valid, in_ready}, 32'h1);

        // R10: latency with consumer always ready
        ready_pct = 100;
        in_valid = 1; in_y = 32'h3F800000; in_x = 32'h7F800000;
        out_ready = 1;
        @(posedge clk); #1;
        in_valid = 0;
        chk(out_valid == 1 && out_result == 32'h00000000, "R10", "one-cycle latency", out_result, 32'h0);
        exp_q.push_back(ref_model(32'h3F800000, 32'h7F800000));
        step(acc);

        // exhaustive pairing of special classes, full throughput
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
                send(pool[i], pool[j]);

        // same under backpressure
        ready_pct = 60;
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
                send(pool[j], pool[i]);

        // random mix with idle gaps
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] a, b;
            a = ($urandom_range(3) == 0) ? $urandom() : pool[$urandom_range(13)];
            b = ($urandom_range(3) == 0) ? $urandom() : pool[$urandom_range(13)];
            if ($urandom_range(4) == 0) step(acc);
            send(a, b);
        end

        // drain
        ready_pct = 100;
        for (int k = 0; k < 10 && exp_q.size() > 0; k++) step(acc);
        chk(exp_q.size() == 0, "R10", "drained", exp_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule